// File: doc/BRIEF.md
# Synchronous Tag Memory with Compare

A single-port synchronous memory of 18-bit words, each made of two 9-bit byte lanes. It serves either as a plain data store or as a cache tag store. All control, address and data inputs are captured on the rising clock edge. A captured cycle is one of three kinds: a read, a write of one or both lanes, or a compare.

A compare cycle works like a read, but its data output stays off. The word on the input bus is captured into the input register at the same edge. The stored word at the captured address is then checked against it, and the result is reported on a match flag.

A mode pin sets the output timing. In flow-through mode, read data and the match result appear in the cycle after the capture edge. In pipelined mode they pass through an output register and appear one clock later. The data output and the match output each have their own asynchronous enable, and an output that is not enabled is reported as not valid. Three chip enables select the device for depth expansion. A sleep input blocks all new cycles and keeps the stored contents.

Top module: `tag_sram`

## Requirements
- R1: A word holds 18 bits, with lane 0 in bits [8:0] and lane 1 in bits [17:9]. A read returns the last word stored at that address.
- R2: With `bwr_n` low, lane i is written only when `lane_n[i]` is also low. A lane whose strobe is high keeps its old value. With `bwr_n` low and both strobes high, nothing changes.
- R3: With `gwr_n` low, both lanes are written whatever `bwr_n` and `lane_n` are.
- R4: A cycle is accepted only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination writes nothing and produces no read output.
- R5: An accepted read with `cmp_n` low is a compare. It gives no valid data output. In its output slot, `match` is 1 exactly when the stored word equals the `din` value captured at the same edge.
- R6: With `flow_mode`=1, the result of a cycle captured at edge k is visible between edges k and k+1. With `flow_mode`=0, it is visible between edges k+1 and k+2.
- R7: `dout_vld` is low at once whenever `oe` is low. `match_vld` follows `match_oe` directly, without waiting for a clock.
- R8: While `sleep` is high, no cycle is accepted and the stored contents are kept.
- R9: `match` is 0 in every output slot that does not carry a compare result.
- R10: While reset is held, and in the first cycle after it, `dout_vld` and `match` are 0.
- R11: A write request takes priority over `cmp_n`. The word is written, and no compare result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control and output registers |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = pipelined timing |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| sleep | input | 1 | Standby; blocks new cycles |
| addr | input | ADDR_W (6) | Word address |
| din | input | 18 | Write data or compare value |
| gwr_n | input | 1 | Write both lanes, active low |
| bwr_n | input | 1 | Lane write enable, active low |
| lane_n | input | 2 | Per-lane write strobes, active low |
| cmp_n | input | 1 | Turns a read into a compare, active low |
| oe | input | 1 | Asynchronous data output enable |
| match_oe | input | 1 | Asynchronous match output enable |
| dout | output | 18 | Read data |
| dout_vld | output | 1 | Read data is present and enabled |
| match | output | 1 | Compare result |
| match_vld | output | 1 | Match output is enabled |

## Verification
A corrupted lane write enable shows up as a wrong lane value on the next read of that address. In flow-through mode that read is seen one cycle after its capture edge. If the captured cycle kind is wrong, a compare can turn into a visible read, a `dout_vld` pulse can go missing, or a stray `match` can appear, all in the very next output slot. A slip in the pipeline register moves results by one cycle. The bench catches this because it checks every cycle, including the empty slots on either side of each expected result.

// File: rtl/tag_sram_pkg.sv
package tag_sram_pkg;
   // Kind of cycle captured at an edge
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_CMP   = 2'd2,
      OP_WRITE = 2'd3
   } tsr_op_e;
endpackage

// File: rtl/tag_sram_ctrl.sv
module tag_sram_ctrl
   import tag_sram_pkg::*;
#(
   parameter int NBYTES = 2
) (
   input  logic              cs_a_n,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic              sleep,
   input  logic              gwr_n,
   input  logic              bwr_n,
   input  logic [NBYTES-1:0] lane_n,
   input  logic              cmp_n,
   output tsr_op_e           op,
   output logic [NBYTES-1:0] lane_we
);
   logic accept;
   logic wr_req;

   assign accept = !cs_a_n && cs_b && !cs_c_n && !sleep;
   assign wr_req = !gwr_n || !bwr_n;

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      assign lane_we[i] = accept && (!gwr_n || (!bwr_n && !lane_n[i]));
   end

   always_comb begin
      if (!accept)     op = OP_IDLE;
      else if (wr_req) op = OP_WRITE;
      else if (!cmp_n) op = OP_CMP;
      else             op = OP_READ;
   end
endmodule

// File: rtl/tag_sram_array.sv
module tag_sram_array #(
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int WORD_W = BYTE_W * NBYTES
) (
   input  logic              clk,
   input  logic [NBYTES-1:0] we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[i]) lane_mem[waddr] <= wdata[i*BYTE_W +: BYTE_W];
      end

      assign rdata[i*BYTE_W +: BYTE_W] = lane_mem[raddr];
   end
endmodule

// File: rtl/tag_sram_outstage.sv
module tag_sram_outstage
   import tag_sram_pkg::*;
#(
   parameter int WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  tsr_op_e           op_q,
   input  logic [WORD_W-1:0] rd_word,
   input  logic [WORD_W-1:0] cmp_word,
   input  logic              oe,
   input  logic              match_oe,
   output logic [WORD_W-1:0] dout,
   output logic              dout_vld,
   output logic              match,
   output logic              match_vld
);
   logic              rd_now;
   logic              hit_now;
   logic              pipe_vld;
   logic              pipe_hit;
   logic [WORD_W-1:0] pipe_word;

   assign rd_now  = (op_q == OP_READ);
   assign hit_now = (op_q == OP_CMP) && (rd_word == cmp_word);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe_vld  <= 1'b0;
         pipe_hit  <= 1'b0;
         pipe_word <= '0;
      end else begin
         pipe_vld <= rd_now;
         pipe_hit <= hit_now;
         if (rd_now) pipe_word <= rd_word;
      end
   end

   assign dout      = flow_mode ? rd_word : pipe_word;
   assign dout_vld  = oe && (flow_mode ? rd_now : pipe_vld);
   assign match     = flow_mode ? hit_now : pipe_hit;
   assign match_vld = match_oe;
endmodule

// File: rtl/tag_sram.sv
module tag_sram
   import tag_sram_pkg::*;
#(
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int WORD_W = BYTE_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              cs_a_n,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] din,
   input  logic              gwr_n,
   input  logic              bwr_n,
   input  logic [NBYTES-1:0] lane_n,
   input  logic              cmp_n,
   input  logic              oe,
   input  logic              match_oe,
   output logic [WORD_W-1:0] dout,
   output logic              dout_vld,
   output logic              match,
   output logic              match_vld
);
   if (BYTE_W < 1) begin : g_bad_byte
      $error("tag_sram: BYTE_W must be at least 1");
   end
   if (NBYTES < 1) begin : g_bad_lanes
      $error("tag_sram: NBYTES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("tag_sram: DEPTH must be at least 2");
   end

   tsr_op_e           op_d;
   tsr_op_e           op_q;
   logic [NBYTES-1:0] lane_we;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] din_q;
   logic [WORD_W-1:0] rd_word;

   tag_sram_ctrl #(.NBYTES(NBYTES)) ctrl_i (
      .cs_a_n (cs_a_n),
      .cs_b   (cs_b),
      .cs_c_n (cs_c_n),
      .sleep  (sleep),
      .gwr_n  (gwr_n),
      .bwr_n  (bwr_n),
      .lane_n (lane_n),
      .cmp_n  (cmp_n),
      .op     (op_d),
      .lane_we(lane_we)
   );

   // Input registers: address, cycle kind and compare value
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         op_q <= op_d;
         if (op_d == OP_READ || op_d == OP_CMP) addr_q <= addr;
         if (op_d == OP_CMP) din_q <= din;
      end
   end

   tag_sram_array #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .DEPTH(DEPTH)) array_i (
      .clk  (clk),
      .we   (lane_we),
      .waddr(addr),
      .wdata(din),
      .raddr(addr_q),
      .rdata(rd_word)
   );

   tag_sram_outstage #(.WORD_W(WORD_W)) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flow_mode(flow_mode),
      .op_q     (op_q),
      .rd_word  (rd_word),
      .cmp_word (din_q),
      .oe       (oe),
      .match_oe (match_oe),
      .dout     (dout),
      .dout_vld (dout_vld),
      .match    (match),
      .match_vld(match_vld)
   );
endmodule

// File: rtl/tag_sram_chk.sv
module tag_sram_chk
   import tag_sram_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       flow_mode,
   input logic       cs_a_n,
   input logic       cs_b,
   input logic       cs_c_n,
   input logic       sleep,
   input logic       oe,
   input logic       match_oe,
   input logic [1:0] op_q,
   input logic       dout_vld,
   input logic       match,
   input logic       match_vld
);
   // R4: a deselected edge captures no cycle
   assert_deselect_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_a_n || !cs_b || cs_c_n) |=> (op_q == OP_IDLE));

   // R8: sleep blocks acceptance
   assert_sleep_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (op_q == OP_IDLE));

   // R5: a compare slot never shows data (flow-through timing)
   assert_cmp_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && op_q == OP_CMP) |-> !dout_vld);

   // R7: output enables gate the valid flags
   assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !dout_vld);
   assert_moe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !match_oe |-> !match_vld);

   // R9: no match outside a compare slot (flow-through timing)
   assert_match_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && op_q != OP_CMP) |-> !match);
endmodule

bind tag_sram tag_sram_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .flow_mode(flow_mode),
   .cs_a_n   (cs_a_n),
   .cs_b     (cs_b),
   .cs_c_n   (cs_c_n),
   .sleep    (sleep),
   .oe       (oe),
   .match_oe (match_oe),
   .op_q     (op_q),
   .dout_vld (dout_vld),
   .match    (match),
   .match_vld(match_vld)
);

// File: tb/tag_sram_tb_top.sv
module tag_sram_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 64;
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int WORD_W = 18;

   typedef struct {
      int              due;
      bit              dvld;
      logic [WORD_W-1:0] dval;
      bit              mt;
      int              req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flow_mode = 1'b1;
   logic cs_a_n = 1'b0, cs_b = 1'b1, cs_c_n = 1'b0, sleep = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [WORD_W-1:0] din = '0;
   logic gwr_n = 1'b1, bwr_n = 1'b1, cmp_n = 1'b1;
   logic [1:0] lane_n = 2'b11;
   logic oe = 1'b1, match_oe = 1'b1;
   logic [WORD_W-1:0] dout;
   logic dout_vld, match, match_vld;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;
   exp_t q[$];
   logic [WORD_W-1:0] model [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tag_sram dut_i (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
      .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .sleep(sleep),
      .addr(addr), .din(din), .gwr_n(gwr_n), .bwr_n(bwr_n),
      .lane_n(lane_n), .cmp_n(cmp_n), .oe(oe), .match_oe(match_oe),
      .dout(dout), .dout_vld(dout_vld), .match(match), .match_vld(match_vld)
   );

   task automatic check(input int req, input string what, input logic [WORD_W-1:0] act,
                        input logic [WORD_W-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h (cycle %0d)", req, what, act, expv, cyc);
      end
   endtask

   // Monitor: every output slot is compared against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         exp_t e;
         e.due = cyc; e.dvld = 0; e.dval = '0; e.mt = 0; e.req = 9;
         if (q.size() > 0 && q[0].due == cyc) e = q.pop_front();
         check(e.req, "dout_vld", {17'd0, dout_vld}, {17'd0, e.dvld & oe});
         if (e.dvld && oe) check(e.req, "dout", dout, e.dval);
         check(7, "match_vld", {17'd0, match_vld}, {17'd0, match_oe});
         if (match_oe) check(e.req, "match", {17'd0, match}, {17'd0, e.mt});
      end
   end

   // Driver: apply current inputs for one cycle, predict, push expectation
   task automatic step(input int req);
      bit acc;
      exp_t e;
      acc = !cs_a_n && cs_b && !cs_c_n && !sleep;
      e.due = cyc + (flow_mode ? 1 : 2); e.req = req; e.dvld = 0; e.dval = '0; e.mt = 0;
      if (acc) begin
         if (!gwr_n || !bwr_n) begin
            if (!gwr_n || !lane_n[0]) model[addr][8:0]  = din[8:0];
            if (!gwr_n || !lane_n[1]) model[addr][17:9] = din[17:9];
         end else if (!cmp_n) begin
            e.mt = (model[addr] == din);
            q.push_back(e);
         end else begin
            e.dvld = 1; e.dval = model[addr];
            q.push_back(e);
         end
      end
      @(posedge clk); #1;
      cs_a_n = 0; cs_b = 1; cs_c_n = 0; sleep = 0;
      gwr_n = 1; bwr_n = 1; lane_n = 2'b11; cmp_n = 1; oe = 1; match_oe = 1;
   endtask

   task automatic wr_all(input int a, input logic [WORD_W-1:0] d, input int req);
      addr = ADDR_W'(a); din = d; gwr_n = 0; step(req);
   endtask
   task automatic rd(input int a, input int req);
      addr = ADDR_W'(a); step(req);
   endtask
   task automatic cmp(input int a, input logic [WORD_W-1:0] d, input int req);
      addr = ADDR_W'(a); din = d; cmp_n = 0; step(req);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin cs_b = 0; step(4); end
   endtask

   task automatic body();
      // R1 / R3: whole-word writes then reads
      wr_all(3, 18'h2A5A5, 3);              // R3
      rd(3, 1);                              // R1
      addr = 4; din = 18'h1C3C3; gwr_n = 0; bwr_n = 0; lane_n = 2'b01; step(3); // R3 strobes ignored
      rd(4, 3);                              // R3
      // R2: lane writes
      addr = 3; din = 18'h3FFFF; bwr_n = 0; lane_n = 2'b10; step(2);  // R2 lane 0
      rd(3, 2);
      addr = 3; din = 18'h00000; bwr_n = 0; lane_n = 2'b01; step(2);  // R2 lane 1
      rd(3, 2);
      addr = 3; din = 18'h12345; bwr_n = 0; lane_n = 2'b11; step(2);  // R2 no strobe
      rd(3, 2);
      // R4: each chip enable alone deselects
      addr = 3; din = 18'h0BEEF; gwr_n = 0; cs_a_n = 1; step(4);
      addr = 3; din = 18'h0BEEF; gwr_n = 0; cs_b = 0;   step(4);
      addr = 3; din = 18'h0BEEF; gwr_n = 0; cs_c_n = 1; step(4);
      addr = 3; cs_c_n = 1; step(4);          // R4 read gives no output
      rd(3, 4);
      // R5: compare hit and miss, then read right after
      cmp(4, 18'h1C3C3, 5);                  // R5 hit
      cmp(4, 18'h1C3C2, 5);                  // R5 miss
      rd(4, 5);
      // R11: write with compare request
      addr = 5; din = 18'h15555; gwr_n = 0; cmp_n = 0; step(11);
      rd(5, 11);
      // R8: sleep blocks write, contents kept
      addr = 5; din = 18'h00001; gwr_n = 0; sleep = 1; step(8);
      addr = 5; sleep = 1; step(8);
      rd(5, 8);
      // R7: enables off during the result slot
      rd(4, 7); oe = 0; match_oe = 0; cmp(4, 18'h1C3C3, 7);
      oe = 0; idle(1);
      // R6: pipelined timing
      idle(2); flow_mode = 0; idle(3);
      rd(3, 6); rd(4, 6); cmp(4, 18'h1C3C3, 6); cmp(5, 18'h0, 6); rd(5, 6);
      idle(1); oe = 0; rd(3, 7); idle(1);
      // R6: mixed traffic in pipelined mode
      for (int i = 0; i < 40; i++) begin
         int a = i % 8;
         case (i % 4)
            0: wr_all(a, 18'((i * 7919) ^ 18'h2D2D2), 6);
            1: rd(a, 6);
            2: cmp(a, model[a] ^ ((i % 8 == 2) ? 18'h0 : 18'h00100), 6);
            default: begin addr = ADDR_W'(a); din = 18'h3FE01; bwr_n = 0; lane_n = 2'(i % 3); step(2); end
         endcase
      end
      idle(3); flow_mode = 1; idle(3);
      rd(0, 6); rd(1, 6); idle(3);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      // R10: state while reset is held
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(10, "dout_vld in reset", {17'd0, dout_vld}, 18'd0);
      check(10, "match in reset", {17'd0, match}, 18'd0);
      // clear array through the normal interface, still holding outputs quiet
      @(posedge clk); #1; rst_n = 1;
      for (int i = 0; i < DEPTH; i++) begin addr = ADDR_W'(i); din = '0; gwr_n = 0; step(10); end
      idle(2);
      body();
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
   end
endmodule